// File: doc/BRIEF.md
# Dual-Channel Half-Rate Sample Splitter

This block takes two streams of 6-bit converter codes, an in-phase (I) channel and a quadrature (Q) channel. Each stream delivers one code per cycle of the fast sample clock. The block splits each stream into two output ports that run at half the rate. Port A carries the even-numbered samples and port B carries the odd-numbered ones. Downstream logic can then take a pair of samples per channel on every cycle of a clock at half the sample rate.

The block also produces that half-rate clock. It merges the per-channel over-range indications into one flag, which travels with the port A sample. Both channels share one phase counter, so the four ports always change together on the edge at which the divided clock rises.

Codes are offset binary, with bit 0 as the least significant bit. 000000 is negative full scale and 111111 is positive full scale. A sample source that is driven past either limit holds the code at that limit and raises its over-range bit. The block carries such codes through unchanged.

Top module: `iqdmx_top`

## Requirements
- R1: While `rst` is sampled high, the next clock edge sets all four ports, `ovr_any` and `clk_half` to zero.
- R2: Starting with the first edge at which `rst` is low, `clk_half` inverts on every fast-clock edge. It is 1 after that first edge.
- R3: Sample 0 is the sample taken at the first edge with `rst` low, and later samples are numbered from it. Every even-numbered I sample appears on `i_port_a` and every odd-numbered I sample appears on `i_port_b`.
- R4: Port A shows its sample two fast cycles after capture, and port B shows its sample one fast cycle after capture. The ports change only on edges at which `clk_half` rises, and they hold their value across the other edges.
- R5: `ovr_any` is the OR of the I and Q over-range bits of the sample pair's even sample. It changes on the same edge as port A. Over-range on an odd sample does not set it.
- R6: Codes pass through without alteration, including the saturated values 000000 and 111111 that arrive with the over-range bit set.
- R7: The Q ports take their samples from the same sample numbers as the I ports, on the same edge.
- R8: A reset in the middle of a stream restarts the numbering. The first sample after the reset is released goes to port A, whatever phase the stream had before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst | input | 1 | Synchronous reset, active high |
| i_code | input | 6 | I-channel code, offset binary |
| i_ovr | input | 1 | I-channel over-range indication |
| q_code | input | 6 | Q-channel code, offset binary |
| q_ovr | input | 1 | Q-channel over-range indication |
| i_port_a | output | 6 | I even samples, half rate |
| i_port_b | output | 6 | I odd samples, half rate |
| q_port_a | output | 6 | Q even samples, half rate |
| q_port_b | output | 6 | Q odd samples, half rate |
| ovr_any | output | 1 | Combined over-range flag, aligned with port A |
| clk_half | output | 1 | Divided clock at half the sample rate |

## Verification
Four properties are checked on every cycle once reset is released:
- the divided clock inverts on each fast-clock edge;
- every lane holds its ports across the edges on which the clock does not rise;
- after an update, port A matches the input from three sampled edges back and port B matches the input from two back;
- the combined flag matches the OR of the two channels' delayed over-range inputs.

Other behaviour can only be shown by the directed scenarios:
- the reset values;
- the numbering restart after a mid-stream reset;
- saturated codes at both full-scale limits;
- over-range that appears only on odd samples and must not raise the flag;
- I and Q streams with different contents landing in step.

The bench rebuilds the expected pair for every edge from the sample numbers.

// File: rtl/iqdmx_pkg.sv
package iqdmx_pkg;
  // Which port the next captured sample belongs to.
  typedef enum logic {
    SLOT_A = 1'b0,
    SLOT_B = 1'b1
  } slot_e;

  localparam int NUM_CH = 2;
  localparam int CH_I   = 0;
  localparam int CH_Q   = 1;
endpackage

// File: rtl/iqdmx_phase.sv
module iqdmx_phase
  import iqdmx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic load,
  output logic clk_half
);
  slot_e slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= SLOT_A;
    else     slot_q <= (slot_q == SLOT_A) ? SLOT_B : SLOT_A;
  end

  // Arrival of an A-slot sample closes the previous pair.
  assign load     = (slot_q == SLOT_A);
  assign clk_half = (slot_q == SLOT_B);

  // R2
  half_clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_half != $past(clk_half)));
endmodule

// File: rtl/iqdmx_lane.sv
module iqdmx_lane #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_ovr,
  output logic [CODE_W-1:0] port_a,
  output logic [CODE_W-1:0] port_b,
  output logic              lead_ovr
);
  logic [CODE_W-1:0] cur_code, prev_code;
  logic              cur_ovr, prev_ovr;

  // Two-deep capture: cur holds the newest sample, prev the one before.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code  <= '0;
      prev_code <= '0;
      cur_ovr   <= 1'b0;
      prev_ovr  <= 1'b0;
    end else begin
      cur_code  <= in_code;
      prev_code <= cur_code;
      cur_ovr   <= in_ovr;
      prev_ovr  <= cur_ovr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_a <= '0;
      port_b <= '0;
    end else if (load) begin
      port_a <= prev_code;
      port_b <= cur_code;
    end
  end

  // Over-range of the even sample about to be loaded into port A.
  assign lead_ovr = prev_ovr;

  // R4
  ports_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(port_a) && $stable(port_b)));

  // R3
  pair_order_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !$past(rst) && !$past(rst, 2)) |=>
      (port_a == $past(in_code, 3) && port_b == $past(in_code, 2)));
endmodule

// File: rtl/iqdmx_ovr_merge.sv
module iqdmx_ovr_merge #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [NCH-1:0] lead_ovr,
  output logic           ovr_any
);
  always_ff @(posedge clk) begin
    if (rst)       ovr_any <= 1'b0;
    else if (load) ovr_any <= |lead_ovr;
  end
endmodule

// File: rtl/iqdmx_top.sv
module iqdmx_top
  import iqdmx_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] i_code,
  input  logic              i_ovr,
  input  logic [CODE_W-1:0] q_code,
  input  logic              q_ovr,
  output logic [CODE_W-1:0] i_port_a,
  output logic [CODE_W-1:0] i_port_b,
  output logic [CODE_W-1:0] q_port_a,
  output logic [CODE_W-1:0] q_port_b,
  output logic              ovr_any,
  output logic              clk_half
);
  logic                         load;
  logic [NUM_CH-1:0][CODE_W-1:0] ch_code, ch_a, ch_b;
  logic [NUM_CH-1:0]             ch_ovr, ch_lead;

  assign ch_code[CH_I] = i_code;
  assign ch_code[CH_Q] = q_code;
  assign ch_ovr[CH_I]  = i_ovr;
  assign ch_ovr[CH_Q]  = q_ovr;

  iqdmx_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .clk_half (clk_half)
  );

  // One lane per channel, all driven by the shared phase (R7).
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    iqdmx_lane #(.CODE_W(CODE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .in_code  (ch_code[c]),
      .in_ovr   (ch_ovr[c]),
      .port_a   (ch_a[c]),
      .port_b   (ch_b[c]),
      .lead_ovr (ch_lead[c])
    );
  end

  iqdmx_ovr_merge #(.NCH(NUM_CH)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .lead_ovr (ch_lead),
    .ovr_any  (ovr_any)
  );

  assign i_port_a = ch_a[CH_I];
  assign i_port_b = ch_b[CH_I];
  assign q_port_a = ch_a[CH_Q];
  assign q_port_b = ch_b[CH_Q];

  // R5
  ovr_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_half && !$past(rst) && !$past(rst, 2)) |=>
      (ovr_any == ($past(i_ovr, 3) || $past(q_ovr, 3))));
endmodule

// File: tb/tb_iqdmx_top.sv
module tb_iqdmx_top;
  localparam int PER = 10;
  localparam int CW  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] i_code = '0, q_code = '0;
  logic          i_ovr = 1'b0, q_ovr = 1'b0;
  logic [CW-1:0] i_port_a, i_port_b, q_port_a, q_port_b;
  logic          ovr_any, clk_half;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  iqdmx_top #(.CODE_W(CW)) dut (
    .clk(clk), .rst(rst),
    .i_code(i_code), .i_ovr(i_ovr), .q_code(q_code), .q_ovr(q_ovr),
    .i_port_a(i_port_a), .i_port_b(i_port_b),
    .q_port_a(q_port_a), .q_port_b(q_port_b),
    .ovr_any(ovr_any), .clk_half(clk_half)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // {ovr, code} for sample k of pattern p
  function automatic logic [6:0] gen_i(int p, int k);
    case (p)
      0: return {1'b0, 6'(k)};
      1: return (k % 2 == 0) ? 7'b1_111111 : 7'b1_000000;
      2: return {(k == 7), 6'(k + 10)};
      default: return {1'b0, 6'(40 - k)};
    endcase
  endfunction

  function automatic logic [6:0] gen_q(int p, int k);
    case (p)
      0: return {1'b0, 6'(63 - k)};
      1: return (k % 2 == 0) ? 7'b0_100000 : 7'b0_011111;
      2: return {(k == 4), 6'(k * 3)};
      default: return {1'b0, 6'(k + 5)};
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 i_port_a", int'(i_port_a), 0);
    chk("R1 i_port_b", int'(i_port_b), 0);
    chk("R1 q_port_a", int'(q_port_a), 0);
    chk("R1 q_port_b", int'(q_port_b), 0);
    chk("R1 ovr_any",  int'(ovr_any), 0);
    chk("R1 clk_half", int'(clk_half), 0);
  endtask

  // Release reset and stream n samples, checking after every edge.
  task automatic run_stream(int p, int n, string tag);
    logic [6:0] gi, gq, hi, hq;
    gi = gen_i(p, 0); gq = gen_q(p, 0);
    rst = 1'b0;
    i_code = gi[5:0]; i_ovr = gi[6]; q_code = gq[5:0]; q_ovr = gq[6];
    for (int k = 1; k <= n + 3; k++) begin
      int e, u;
      @(negedge clk);
      e = k - 1;
      u = (e % 2 == 0) ? e : e - 1;
      chk("R2 clk_half", int'(clk_half), (e % 2 == 0) ? 1 : 0);
      if (u >= 2) begin
        gi = gen_i(p, u - 2); gq = gen_q(p, u - 2);
        hi = gen_i(p, u - 1); hq = gen_q(p, u - 1);
        chk({tag, " i_port_a even"}, int'(i_port_a), int'(gi[5:0]));
        chk("R4 i_port_b odd",       int'(i_port_b), int'(hi[5:0]));
        chk("R7 q_port_a",           int'(q_port_a), int'(gq[5:0]));
        chk("R7 q_port_b",           int'(q_port_b), int'(hq[5:0]));
        chk("R5 ovr_any",            int'(ovr_any),  int'(gi[6] | gq[6]));
      end else begin
        chk({tag, " i_port_a idle"}, int'(i_port_a), 0);
        chk("R4 i_port_b idle",      int'(i_port_b), 0);
        chk("R5 ovr_any idle",       int'(ovr_any),  0);
      end
      gi = gen_i(p, k); gq = gen_q(p, k);
      i_code = gi[5:0]; i_ovr = gi[6]; q_code = gq[5:0]; q_ovr = gq[6];
    end
  endtask

  task automatic t_counting();   do_reset(); run_stream(0, 20, "R3"); endtask
  task automatic t_saturation(); do_reset(); run_stream(1, 12, "R6"); endtask
  task automatic t_ovr_phase();  do_reset(); run_stream(2, 12, "R5"); endtask
  task automatic t_restart();
    do_reset(); run_stream(0, 6, "R3");
    // stream stopped mid-pair; reset must clear and renumber
    do_reset(); run_stream(3, 12, "R8");
  endtask

  initial begin
    t_counting();
    t_saturation();
    t_ovr_phase();
    t_restart();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PER * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog all-R act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule